// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This unit sits beside a five-stage in-order pipeline and decides, every cycle, whether an exception is taken and on whose behalf. The fetch, decode, execute and memory stages each present a valid flag, a fault flag for the one kind of fault that stage can raise, and the PC of the instruction they hold. An external interrupt request line is also sampled. The write-back stage raises nothing and is never squashed, so whatever has reached it always completes.

When several requests arrive together, the request from the oldest instruction wins. The oldest instruction is the one furthest down the pipe. An interrupt has no instruction of its own, so it is charged to the oldest valid instruction. In the cycle the decision is made, the winning stage and every younger stage are squashed into bubbles. On the next clock edge the winner's PC goes into the exception PC register and its cause code into the cause register. Interrupts are then masked, and a one-cycle redirect presents the handler address to fetch.

The handler address is chosen by a mode input. It is either one fixed entry, or a base address plus a per-cause slot 0x20 bytes wide. A return request restores fetch to the saved PC and unmasks interrupts.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, epc is 0, cause is 0, exc_en is 1, redir_vld is 0 and no flush output is high.
- R2: Stage age is ordered memory (oldest), then execute, then decode, then fetch (youngest). Among simultaneous requests, the request from the oldest stage is taken.
- R3: The cycle after a take, epc holds the PC of the winning stage.
- R4: The cycle after a take, cause holds the code of the request taken: 0 for interrupt, 1 for bad opcode (decode), 2 for overflow (execute), 3 for fetch fault (fetch), 4 for data access fault (memory).
- R5: In the cycle of a take, the flush outputs are high combinationally for the winning stage and every younger stage, and low for every older stage. With no take, all flush outputs are low.
- R6: redir_vld is high for exactly the one cycle after a take or a return. After a take with vec_mode low, redir_pc is 0x8000_0018.
- R7: After a take with vec_mode high, redir_pc is 0xC000_0000 + 0x20 × slot. The slot is 0 for bad opcode, 1 for overflow, 2 for fetch fault, 3 for data fault and 4 for interrupt.
- R8: A pending interrupt is charged to the oldest valid stage. A fault in that same stage takes precedence, with its own cause. The interrupt beats faults in younger stages. With no valid stage, the interrupt is not taken.
- R9: irq_req has no effect while exc_en is 0, and any take clears exc_en on the next edge.
- R10: A return with no take in the same cycle gives, on the next cycle, redir_vld high, redir_pc equal to the saved epc, and exc_en set to 1. A return in the same cycle as a take is ignored.
- R11: A fault flag on a stage whose valid flag is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_vld | input | 1 | Fetch stage holds an instruction |
| if_fetch_flt | input | 1 | Fetch stage reports an instruction fetch fault |
| if_pc | input | AW | PC of the fetch stage instruction |
| id_vld | input | 1 | Decode stage holds an instruction |
| id_bad_op | input | 1 | Decode stage reports an undefined opcode |
| id_pc | input | AW | PC of the decode stage instruction |
| ex_vld | input | 1 | Execute stage holds an instruction |
| ex_ovf | input | 1 | Execute stage reports an arithmetic overflow |
| ex_pc | input | AW | PC of the execute stage instruction |
| mem_vld | input | 1 | Memory stage holds an instruction |
| mem_data_flt | input | 1 | Memory stage reports a data access fault |
| mem_pc | input | AW | PC of the memory stage instruction |
| irq_req | input | 1 | External interrupt request, synchronised to clk |
| vec_mode | input | 1 | 1 selects per-cause vectored entries, 0 the single fixed entry |
| eret | input | 1 | Return from exception request |
| flush_if | output | 1 | Squash the fetch stage this cycle |
| flush_id | output | 1 | Squash the decode stage this cycle |
| flush_ex | output | 1 | Squash the execute stage this cycle |
| flush_mem | output | 1 | Squash the memory stage this cycle |
| epc | output | AW | Saved exception PC |
| cause | output | CW | Saved cause code |
| exc_en | output | 1 | Interrupt enable |
| redir_vld | output | 1 | Fetch redirect strobe, one cycle |
| redir_pc | output | AW | Fetch redirect target |

## Verification
A wrong winner shows at the flush outputs in the same cycle as the requests, and as a wrong epc and cause one edge later. A stale or mis-set enable flag hides until the next interrupt request. The bench therefore re-raises interrupts after both takes and returns. A wrong handler slot or a redirect that is held too long shows on redir_pc and redir_vld in the cycle right after the take. The reference model compares every one of these outputs on every clock, so any divergence is reported within one cycle of its cause.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NUM_STAGES = 4;   // 0 fetch, 1 decode, 2 execute, 3 memory
   localparam int NUM_CAUSES = 5;
   localparam int CAUSE_W    = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CS_IRQ    = 3'd0,
      CS_BADOP  = 3'd1,
      CS_OVF    = 3'd2,
      CS_IFETCH = 3'd3,
      CS_DATA   = 3'd4
   } exc_cause_e;

   function automatic exc_cause_e stage_cause(input int unsigned stg);
      case (stg)
         0:       return CS_IFETCH;
         1:       return CS_BADOP;
         2:       return CS_OVF;
         default: return CS_DATA;
      endcase
   endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
   parameter int NST = 4,
   localparam int SW = (NST > 1) ? $clog2(NST) : 1
) (
   input  logic [NST-1:0] valid,
   input  logic [NST-1:0] fault,
   input  logic           irq_act,
   output logic           take,
   output logic [SW-1:0]  sel,
   output logic           sel_irq,
   output logic [NST-1:0] flush
);

   logic [NST:0]   above_v;
   logic [NST:0]   above_h;
   logic [NST-1:0] hit;
   logic [NST-1:0] win;

   assign above_v[NST] = 1'b0;
   assign above_h[NST] = 1'b0;

   for (genvar g = NST - 1; g >= 0; g--) begin : g_stage
      logic oldest;
      assign oldest       = valid[g] & ~above_v[g+1];
      assign hit[g]       = valid[g] & (fault[g] | (irq_act & oldest));
      assign above_v[g]   = above_v[g+1] | valid[g];
      assign above_h[g]   = above_h[g+1] | hit[g];
      assign win[g]       = hit[g] & ~above_h[g+1];
      assign flush[g]     = above_h[g];
   end

   assign take = above_h[0];

   always_comb begin
      sel     = '0;
      sel_irq = 1'b0;
      for (int i = 0; i < NST; i++) begin
         if (win[i]) begin
            sel     = SW'(i);
            sel_irq = ~fault[i];
         end
      end
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
   parameter int          AW          = 32,
   parameter int          CW          = 3,
   parameter int          NCAUSE      = 5,
   parameter logic [AW-1:0] FIXED_ENTRY = 32'h8000_0018,
   parameter logic [AW-1:0] VEC_BASE    = 32'hC000_0000,
   parameter int          VEC_STRIDE  = 32'h20
) (
   input  logic          vec_mode,
   input  logic [CW-1:0] cause_in,
   output logic [AW-1:0] handler
);

   localparam bit STRIDE_POW2 = (VEC_STRIDE & (VEC_STRIDE - 1)) == 0;
   localparam int SHIFT       = $clog2(VEC_STRIDE);

   if (VEC_STRIDE <= 0) begin : g_bad_stride
      $error("exc_vector_gen: VEC_STRIDE must be positive");
   end

   // slot order: synchronous causes first, interrupt in the last slot
   logic [CW-1:0] slot;
   logic [AW-1:0] offset;

   assign slot = (cause_in == '0) ? CW'(NCAUSE - 1) : cause_in - CW'(1);

   if (STRIDE_POW2) begin : g_shift
      assign offset = AW'(slot) << SHIFT;
   end else begin : g_mul
      assign offset = AW'(slot) * AW'(VEC_STRIDE);
   end

   assign handler = vec_mode ? (VEC_BASE + offset) : FIXED_ENTRY;

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
   parameter int AW        = 32,
   parameter int CW        = 3,
   parameter bit EN_RESET  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [AW-1:0] take_pc,
   input  logic [CW-1:0] take_cause,
   input  logic [AW-1:0] handler,
   input  logic          eret,
   output logic [AW-1:0] epc,
   output logic [CW-1:0] cause,
   output logic          exc_en,
   output logic          redir_vld,
   output logic [AW-1:0] redir_pc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc       <= '0;
         cause     <= '0;
         exc_en    <= EN_RESET;
         redir_vld <= 1'b0;
         redir_pc  <= '0;
      end else begin
         redir_vld <= take | eret;
         if (take) begin
            epc      <= take_pc;
            cause    <= take_cause;
            exc_en   <= 1'b0;
            redir_pc <= handler;
         end else if (eret) begin
            exc_en   <= 1'b1;
            redir_pc <= epc;
         end
      end
   end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
   import exc_pkg::*;
#(
   parameter int            AW          = 32,
   parameter int            CW          = CAUSE_W,
   parameter logic [AW-1:0] FIXED_ENTRY = 32'h8000_0018,
   parameter logic [AW-1:0] VEC_BASE    = 32'hC000_0000,
   parameter int            VEC_STRIDE  = 32'h20,
   parameter bit            EN_RESET    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          if_vld,
   input  logic          if_fetch_flt,
   input  logic [AW-1:0] if_pc,
   input  logic          id_vld,
   input  logic          id_bad_op,
   input  logic [AW-1:0] id_pc,
   input  logic          ex_vld,
   input  logic          ex_ovf,
   input  logic [AW-1:0] ex_pc,
   input  logic          mem_vld,
   input  logic          mem_data_flt,
   input  logic [AW-1:0] mem_pc,
   input  logic          irq_req,
   input  logic          vec_mode,
   input  logic          eret,
   output logic          flush_if,
   output logic          flush_id,
   output logic          flush_ex,
   output logic          flush_mem,
   output logic [AW-1:0] epc,
   output logic [CW-1:0] cause,
   output logic          exc_en,
   output logic          redir_vld,
   output logic [AW-1:0] redir_pc
);

   localparam int SW = $clog2(NUM_STAGES);

   if (AW < 8) begin : g_bad_aw
      $error("exc_ctrl: AW too small");
   end
   if (CW < CAUSE_W) begin : g_bad_cw
      $error("exc_ctrl: CW cannot hold every cause code");
   end

   logic [NUM_STAGES-1:0] st_vld;
   logic [NUM_STAGES-1:0] st_flt;
   logic [NUM_STAGES-1:0] st_flush;
   logic [AW-1:0]         st_pc [NUM_STAGES];

   assign st_vld = {mem_vld, ex_vld, id_vld, if_vld};
   assign st_flt = {mem_data_flt, ex_ovf, id_bad_op, if_fetch_flt};
   assign st_pc[0] = if_pc;
   assign st_pc[1] = id_pc;
   assign st_pc[2] = ex_pc;
   assign st_pc[3] = mem_pc;

   logic          take;
   logic [SW-1:0] sel;
   logic          sel_irq;
   logic [CW-1:0] take_cause;
   logic [AW-1:0] handler;

   exc_prio_sel #(.NST(NUM_STAGES)) u_sel (
      .valid   (st_vld),
      .fault   (st_flt),
      .irq_act (irq_req & exc_en),
      .take    (take),
      .sel     (sel),
      .sel_irq (sel_irq),
      .flush   (st_flush)
   );

   assign take_cause = sel_irq ? CW'(CS_IRQ) : CW'(stage_cause(32'(sel)));

   exc_vector_gen #(
      .AW(AW), .CW(CW), .NCAUSE(NUM_CAUSES),
      .FIXED_ENTRY(FIXED_ENTRY), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_vec (
      .vec_mode (vec_mode),
      .cause_in (take_cause),
      .handler  (handler)
   );

   exc_state_regs #(.AW(AW), .CW(CW), .EN_RESET(EN_RESET)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .take_pc    (st_pc[sel]),
      .take_cause (take_cause),
      .handler    (handler),
      .eret       (eret),
      .epc        (epc),
      .cause      (cause),
      .exc_en     (exc_en),
      .redir_vld  (redir_vld),
      .redir_pc   (redir_pc)
   );

   assign flush_if  = st_flush[0];
   assign flush_id  = st_flush[1];
   assign flush_ex  = st_flush[2];
   assign flush_mem = st_flush[3];

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
   parameter int            AW          = 32,
   parameter int            CW          = 3,
   parameter logic [AW-1:0] FIXED_ENTRY = 32'h8000_0018
) (
   input logic          clk,
   input logic          rst_n,
   input logic          if_vld,
   input logic          if_fetch_flt,
   input logic          id_vld,
   input logic          id_bad_op,
   input logic          ex_vld,
   input logic          ex_ovf,
   input logic          mem_vld,
   input logic          mem_data_flt,
   input logic [AW-1:0] mem_pc,
   input logic          irq_req,
   input logic          vec_mode,
   input logic          eret,
   input logic          flush_if,
   input logic          flush_id,
   input logic          flush_ex,
   input logic          flush_mem,
   input logic [AW-1:0] epc,
   input logic [CW-1:0] cause,
   input logic          exc_en,
   input logic          redir_vld,
   input logic [AW-1:0] redir_pc
);

   logic any_sync;
   assign any_sync = (if_vld & if_fetch_flt) | (id_vld & id_bad_op) |
                     (ex_vld & ex_ovf) | (mem_vld & mem_data_flt);

   AST_FLUSH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_mem || flush_ex) && (!flush_ex || flush_id) && (!flush_id || flush_if)); // R5

   AST_MEM_EPC: assert property (@(posedge clk) disable iff (!rst_n)
      flush_mem |=> epc == $past(mem_pc)); // R3

   AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      flush_if |=> !exc_en); // R9

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_en && irq_req && !any_sync) |-> !flush_if); // R9

   AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_if || eret) |=> redir_vld); // R6

   AST_REDIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush_if || eret) |=> !redir_vld); // R6

   AST_FIXED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_if && !vec_mode) |=> redir_pc == FIXED_ENTRY); // R6

   AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cause <= CW'(4)); // R4

   AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!if_vld && !id_vld && !ex_vld && !mem_vld) |-> !flush_if); // R11

endmodule

bind exc_ctrl exc_ctrl_chk #(.AW(AW), .CW(CW), .FIXED_ENTRY(FIXED_ENTRY)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .if_vld(if_vld), .if_fetch_flt(if_fetch_flt),
   .id_vld(id_vld), .id_bad_op(id_bad_op),
   .ex_vld(ex_vld), .ex_ovf(ex_ovf),
   .mem_vld(mem_vld), .mem_data_flt(mem_data_flt), .mem_pc(mem_pc),
   .irq_req(irq_req), .vec_mode(vec_mode), .eret(eret),
   .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex), .flush_mem(flush_mem),
   .epc(epc), .cause(cause), .exc_en(exc_en),
   .redir_vld(redir_vld), .redir_pc(redir_pc)
);

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [3:0]  v, f;      // index 0 fetch .. 3 memory
   logic [31:0] pc [4];
   logic        irq, vm, er;

   logic        fl_if, fl_id, fl_ex, fl_mem, en_o, rv_o;
   logic [31:0] epc_o, rpc_o;
   logic [2:0]  cause_o;

   exc_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .if_vld(v[0]), .if_fetch_flt(f[0]), .if_pc(pc[0]),
      .id_vld(v[1]), .id_bad_op(f[1]), .id_pc(pc[1]),
      .ex_vld(v[2]), .ex_ovf(f[2]), .ex_pc(pc[2]),
      .mem_vld(v[3]), .mem_data_flt(f[3]), .mem_pc(pc[3]),
      .irq_req(irq), .vec_mode(vm), .eret(er),
      .flush_if(fl_if), .flush_id(fl_id), .flush_ex(fl_ex), .flush_mem(fl_mem),
      .epc(epc_o), .cause(cause_o), .exc_en(en_o),
      .redir_vld(rv_o), .redir_pc(rpc_o)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference state
   logic [31:0] m_epc = 0, m_rpc = 0;
   logic [2:0]  m_cause = 0;
   logic        m_en = 1, m_rv = 0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic cyc(input string tag);
      int tgt, win;
      logic [3:0]  efl;
      logic [2:0]  ec;
      logic [31:0] hnd;
      int code [4] = '{3, 1, 2, 4};
      @(negedge clk); #2;
      tgt = -1;
      for (int s = 3; s >= 0; s--) if (tgt < 0 && v[s]) tgt = s;
      win = -1;
      for (int s = 3; s >= 0; s--)
         if (win < 0 && v[s] && (f[s] || (irq && m_en && s == tgt))) win = s;
      efl = '0;
      for (int s = 0; s < 4; s++) if (win >= s) efl[s] = 1'b1;
      chk(tag, "flush", {28'd0, fl_mem, fl_ex, fl_id, fl_if}, {28'd0, efl});
      chk(tag, "epc", epc_o, m_epc);
      chk(tag, "cause", {29'd0, cause_o}, {29'd0, m_cause});
      chk(tag, "exc_en", {31'd0, en_o}, {31'd0, m_en});
      chk(tag, "redir_vld", {31'd0, rv_o}, {31'd0, m_rv});
      if (m_rv) chk(tag, "redir_pc", rpc_o, m_rpc);
      ec = 0; hnd = 32'h8000_0018;
      if (win >= 0) begin
         ec = f[win] ? 3'(code[win]) : 3'd0;
         if (vm) hnd = 32'hC000_0000 + 32'h20 * ((ec == 0) ? 4 : ec - 1);
      end
      @(posedge clk); #1;
      if (win >= 0) begin
         m_epc = pc[win]; m_cause = ec; m_en = 0; m_rv = 1; m_rpc = hnd;
      end else if (er) begin
         m_rv = 1; m_rpc = m_epc; m_en = 1;
      end else begin
         m_rv = 0;
      end
   endtask

   task automatic idle();
      v = 0; f = 0; irq = 0; er = 0;
   endtask

   task automatic shot(input string tag, input logic [3:0] vv, input logic [3:0] ff,
                       input logic ii, input logic mm, input logic ee);
      v = vv; f = ff; irq = ii; vm = mm; er = ee;
      cyc(tag);
      idle();
      cyc(tag);   // observe saved state and redirect
      cyc(tag);   // redirect must drop
   endtask

   initial begin
      pc[0] = 32'h0000_1010; pc[1] = 32'h0000_100C;
      pc[2] = 32'h0000_1008; pc[3] = 32'h0000_1004;
      idle(); vm = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc("R1");
      cyc("R1");
      // single fetch fault, fixed entry
      shot("R3_R5_R6", 4'b1111, 4'b0001, 0, 0, 0);
      // decode and fetch together: decode is older
      shot("R2", 4'b1111, 4'b0011, 0, 0, 0);
      // all four faulting: memory wins, vectored
      shot("R2_R7", 4'b1111, 4'b1111, 0, 1, 0);
      shot("R7_R4", 4'b0111, 4'b0110, 0, 1, 0);
      shot("R7_R4", 4'b0011, 4'b0010, 0, 1, 0);
      shot("R7_R4", 4'b0001, 4'b0001, 0, 1, 0);
      // interrupt while disabled
      shot("R9", 4'b1111, 4'b0000, 1, 1, 0);
      // return re-enables
      shot("R10", 4'b0000, 4'b0000, 0, 0, 1);
      shot("R8", 4'b1111, 4'b0000, 1, 1, 0);        // charged to memory
      shot("R10", 4'b0000, 4'b0000, 0, 1, 1);
      shot("R8", 4'b0110, 4'b0010, 1, 1, 0);        // to execute, beats decode fault
      shot("R10", 4'b0000, 4'b0000, 0, 1, 1);
      shot("R8", 4'b1001, 4'b1000, 1, 1, 0);        // memory fault wins over irq
      shot("R10", 4'b0000, 4'b0000, 0, 0, 1);
      shot("R8", 4'b0000, 4'b0000, 1, 0, 0);        // no valid stage: not taken
      shot("R11", 4'b0000, 4'b1111, 0, 0, 0);       // faults on empty stages
      shot("R11", 4'b0101, 4'b1010, 1, 0, 0);       // invalid faults, irq to execute
      shot("R10", 4'b1111, 4'b0100, 0, 0, 1);       // return together with take
      shot("R10", 4'b0000, 4'b0000, 0, 1, 1);
      // random traffic
      for (int n = 0; n < 2000; n++) begin
         v = 4'($urandom); f = 4'($urandom & $urandom);
         irq = 1'($urandom % 3 == 0); vm = 1'($urandom);
         er = 1'($urandom % 5 == 0);
         for (int s = 0; s < 4; s++) pc[s] = $urandom & 32'hFFFF_FFFC;
         cyc("R2_R5_R8");
      end
      idle();
      cyc("R6");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R1: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule